// File: doc/BRIEF.md
# Handshake Conditional Selection Unit

This block computes a two-way conditional over a data word behind a load/done handshake. A caller raises `load` while the block is idle, and the block starts a test unit on the live input word. When the test finishes, the block starts exactly one of two branch units on a copy of the input that it captured at start. The chosen branch's result is then driven on `out`, and `done` goes high again once every sub-unit is idle.

The three sub-units share one generic atomic handshake unit. Each instance is given a function and a busy latency. By default the test asks whether the operand is zero, the true branch passes the operand through, and the false branch subtracts one. The branch latencies differ (2 and 3 cycles by default), so the branch taken can be seen in the handshake timing. All edge-detector delay registers reset to 1, so after reset every sub-unit reads idle and the block is ready with `done` high.

Top module: `hs_cond_sel`

## Requirements
- R1: After a synchronous reset, `done` is 1 and `out` is 0.
- R2: A start occurs only in a cycle where `load` is 1 and was 0 at the previous clock edge, and `done` was 1 at that edge. A `load` rise while the block is busy is ignored and does not change the result of the operation in flight.
- R3: `done` drops to 0 combinationally in the start cycle. It returns to 1 exactly TEST_LAT + B + 2 clock edges after the start edge, where B is THEN_LAT or ELSE_LAT, whichever branch was taken.
- R4: The test sees `inp` as sampled at the start edge, and both branches use the operand captured at that edge. Changes to `inp` after start have no effect on the result.
- R5: If the test result is nonzero (default: operand equals 0), the true branch runs and `out` equals its result (default: the operand unchanged).
- R6: If the test result is zero (default: operand is nonzero), the false branch runs and `out` equals its result (default: operand minus 1, modulo 2^DATA_W).
- R7: At most one branch unit is started per operation, and only in the cycle where the test unit's done rises. The latency therefore follows the branch taken (default 5 cycles for the true branch, 6 for the false branch).
- R8: While `done` stays high, `out` does not change.
- R9: Holding `load` high after an operation finishes does not start another one. Only a new 0-to-1 transition of `load` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Request; a rising edge while idle starts an operation |
| inp | input | DATA_W | Operand word, sampled at the start edge |
| done | output | 1 | High when all three sub-units are idle |
| out | output | DATA_W | Result of the selected branch, valid while done is high |

## Verification
The checker attached to the top verifies several properties on every cycle. It checks that starts happen only on a load rise and pull `done` low in the same cycle. It checks that no more than one branch unit is ever started, and that a branch starts only when the test unit's done rises. It also checks that `out` holds steady while `done` remains high. Other behaviours need the bench's scenarios and its cycle model: the exact completion latency per branch, the branch results for zero and nonzero operands including wraparound, immunity to input changes and to load pulses while busy, and the absence of a restart when load is held high.

// File: rtl/hs_cond_pkg.sv
package hs_cond_pkg;

  // Function performed by one atomic handshake unit.
  typedef enum logic [1:0] {
    FN_IS_ZERO = 2'd0,
    FN_PASS    = 2'd1,
    FN_DEC     = 2'd2,
    FN_INC     = 2'd3
  } unit_fn_e;

endpackage

// File: rtl/hs_rise_det.sv
module hs_rise_det #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);

  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= RST_VAL;
    else     sig_q <= sig;
  end

  assign rise = sig & ~sig_q;

endmodule

// File: rtl/hs_atom_unit.sv
module hs_atom_unit
  import hs_cond_pkg::*;
#(
  parameter int       DATA_W = 8,
  parameter int       LAT    = 1,
  parameter unit_fn_e FN     = FN_PASS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] arg,
  output logic              done,
  output logic [DATA_W-1:0] res
);

  localparam int CNT_W = (LAT < 1) ? 1 : $clog2(LAT + 1);

  logic [CNT_W-1:0]  busy_cnt;
  logic [DATA_W-1:0] fn_val;

  generate
    if (FN == FN_IS_ZERO) begin : g_zero
      assign fn_val = DATA_W'(arg == '0);
    end else if (FN == FN_DEC) begin : g_dec
      assign fn_val = arg - DATA_W'(1);
    end else if (FN == FN_INC) begin : g_inc
      assign fn_val = arg + DATA_W'(1);
    end else begin : g_pass
      assign fn_val = arg;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      res      <= '0;
    end else if (start) begin
      busy_cnt <= CNT_W'(LAT);
      res      <= fn_val;
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - CNT_W'(1);
    end
  end

  // Done drops in the start cycle itself so that no gap appears upstream.
  assign done = (busy_cnt == '0) & ~start;

endmodule

// File: rtl/hs_cond_sel.sv
module hs_cond_sel
  import hs_cond_pkg::*;
#(
  parameter int       DATA_W   = 8,
  parameter int       TEST_LAT = 1,
  parameter int       THEN_LAT = 2,
  parameter int       ELSE_LAT = 3,
  parameter unit_fn_e TEST_FN  = FN_IS_ZERO,
  parameter unit_fn_e THEN_FN  = FN_PASS,
  parameter unit_fn_e ELSE_FN  = FN_DEC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] inp,
  output logic              done,
  output logic [DATA_W-1:0] out
);

  logic              load_rise;
  logic              done_q;
  logic              start;
  logic [DATA_W-1:0] op_q;
  logic              t_done, t_rise, t_flag;
  logic [DATA_W-1:0] t_res;
  logic              sel_q;
  logic              th_start, el_start;
  logic              th_done, el_done;
  logic [DATA_W-1:0] th_res, el_res;

  hs_rise_det #(.RST_VAL(1'b1)) u_load_rise (
    .clk(clk), .rst(rst), .sig(load), .rise(load_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b1;
    else     done_q <= done;
  end

  assign start = load_rise & done_q;

  always_ff @(posedge clk) begin
    if (rst)        op_q <= '0;
    else if (start) op_q <= inp;
  end

  hs_atom_unit #(.DATA_W(DATA_W), .LAT(TEST_LAT), .FN(TEST_FN)) u_test (
    .clk(clk), .rst(rst), .start(start), .arg(inp),
    .done(t_done), .res(t_res)
  );

  assign t_flag = |t_res;

  hs_rise_det #(.RST_VAL(1'b1)) u_tdone_rise (
    .clk(clk), .rst(rst), .sig(t_done), .rise(t_rise)
  );

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 1'b0;
    else if (t_rise) sel_q <= t_flag;
  end

  assign th_start = t_rise & t_flag;
  assign el_start = t_rise & ~t_flag;

  hs_atom_unit #(.DATA_W(DATA_W), .LAT(THEN_LAT), .FN(THEN_FN)) u_then (
    .clk(clk), .rst(rst), .start(th_start), .arg(op_q),
    .done(th_done), .res(th_res)
  );

  hs_atom_unit #(.DATA_W(DATA_W), .LAT(ELSE_LAT), .FN(ELSE_FN)) u_else (
    .clk(clk), .rst(rst), .start(el_start), .arg(op_q),
    .done(el_done), .res(el_res)
  );

  assign out  = sel_q ? th_res : el_res;
  assign done = t_done & th_done & el_done;

endmodule

// File: rtl/hs_cond_sel_chk.sv
module hs_cond_sel_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic              done,
  input logic [DATA_W-1:0] out,
  input logic              start,
  input logic              t_done,
  input logic              th_start,
  input logic              el_start
);

  a_r2_start_on_load_rise: assert property (@(posedge clk) disable iff (rst)
    start |-> $rose(load));

  a_r3_done_low_at_start: assert property (@(posedge clk) disable iff (rst)
    start |-> !done);

  a_r7_one_branch: assert property (@(posedge clk) disable iff (rst)
    $onehot0({th_start, el_start}));

  a_r7_branch_after_test: assert property (@(posedge clk) disable iff (rst)
    (th_start || el_start) |-> $rose(t_done));

  a_r8_out_stable: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(out));

endmodule

bind hs_cond_sel hs_cond_sel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .done(done), .out(out),
  .start(start), .t_done(t_done), .th_start(th_start), .el_start(el_start)
);

// File: tb/sim_hs_cond_sel.sv
`timescale 1ns/1ps
module sim_hs_cond_sel;

  localparam int DW  = 8;
  localparam int TL  = 1;
  localparam int THL = 2;
  localparam int ELL = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic [DW-1:0] inp = '0;
  logic          done;
  logic [DW-1:0] out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  hs_cond_sel #(.DATA_W(DW), .TEST_LAT(TL), .THEN_LAT(THL), .ELSE_LAT(ELL)) u0 (
    .clk(clk), .rst(rst), .load(load), .inp(inp), .done(done), .out(out)
  );

  // Behavioural cycle model
  int            m_rem = 0;
  logic          m_pl  = 1'b1;
  logic          m_pd  = 1'b1;
  logic [DW-1:0] m_res = '0;

  function automatic logic m_start();
    return load && !m_pl && m_pd;
  endfunction

  function automatic logic m_done();
    return !m_start() && (m_rem == 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rem = 0; m_pl = 1'b1; m_pd = 1'b1; m_res = '0;
    end else begin
      logic st;
      st   = m_start();
      m_pd = m_done();
      if (st) begin
        m_rem = TL + ((inp == '0) ? THL : ELL) + 1;
        m_res = (inp == '0) ? inp : inp - DW'(1);
      end else if (m_rem > 0) begin
        m_rem = m_rem - 1;
      end
      m_pl = load;
    end
  end

  // Per-cycle comparison in mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (done !== m_done()) begin
        errors++;
        $display("FAIL R3 cycle %0d done actual %b expected %b", cyc, done, m_done());
      end
      if (m_done()) begin
        checks++;
        if (out !== m_res) begin
          errors++;
          $display("FAIL R5/R6 cycle %0d out actual %0d expected %0d", cyc, out, m_res);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected below 100000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // Run one operation; optionally change inp after start, or pulse load mid-flight.
  task automatic run_op(input logic [DW-1:0] v, input bit flip, input bit repulse,
                        output int lat);
    @(posedge clk); #1;
    load = 1'b1; inp = v;
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
      if (flip) inp = ~v;
      if (repulse && lat == 2) load = 1'b0;
      if (repulse && lat == 3) load = 1'b1;
    end while (!done && lat < 50);
    load = 1'b0;
  endtask

  initial begin
    int lat;
    idle(4);
    rst = 1'b0;
    #1;
    chk("R1 done after reset", int'(done), 1);
    chk("R1 out after reset", int'(out), 0);
    idle(2);

    // R5: zero operand takes the true branch
    run_op(8'd0, 1'b0, 1'b0, lat);
    chk("R5 out for zero", int'(out), 0);
    chk("R3 R7 latency true branch", lat, TL + THL + 2);

    // R6: nonzero operand takes the false branch
    run_op(8'd37, 1'b0, 1'b0, lat);
    chk("R6 out for 37", int'(out), 36);
    chk("R3 R7 latency false branch", lat, TL + ELL + 2);

    run_op(8'd1, 1'b0, 1'b0, lat);
    chk("R6 out for 1", int'(out), 0);
    run_op(8'd255, 1'b0, 1'b0, lat);
    chk("R6 out for 255", int'(out), 254);

    // R5 after a false-branch op: selection must switch back
    run_op(8'd0, 1'b0, 1'b0, lat);
    chk("R5 switch back to true branch", int'(out), 0);
    chk("R7 latency true again", lat, TL + THL + 2);

    // R4: inp changes right after start
    run_op(8'd0, 1'b1, 1'b0, lat);
    chk("R4 zero operand captured", int'(out), 0);
    chk("R4 latency follows captured operand", lat, TL + THL + 2);
    run_op(8'd20, 1'b1, 1'b0, lat);
    chk("R4 nonzero operand captured", int'(out), 19);

    // R2: a load pulse while busy is ignored
    run_op(8'd9, 1'b0, 1'b1, lat);
    chk("R2 result unaffected by busy load", int'(out), 8);
    chk("R2 latency unaffected by busy load", lat, TL + ELL + 2);

    // R9: load held high after completion does not restart
    @(posedge clk); #1;
    load = 1'b1; inp = 8'd50;
    idle(TL + ELL + 3);
    chk("R9 first op out", int'(out), 49);
    inp = 8'd0;
    idle(6);
    chk("R9 done stays high with load held", int'(done), 1);
    chk("R9 R8 out unchanged with load held", int'(out), 49);
    load = 1'b0;
    idle(2);

    // R8: out steady while idle with inputs wiggling
    inp = 8'd3;
    idle(3);
    chk("R8 out steady while idle", int'(out), 49);

    // Back-to-back: load drops and rises immediately
    run_op(8'd128, 1'b0, 1'b0, lat);
    chk("R6 out for 128", int'(out), 127);
    run_op(8'd0, 1'b0, 1'b0, lat);
    chk("R5 back-to-back zero", int'(out), 0);

    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule